// File: doc/BRIEF.md
# Stage Counter and Compare-Branch Unit

This block is the program-flow stage of a small low-power coprocessor. Each cycle it takes the 32-bit instruction being executed and decodes it. From that word, the current program counter, the value of R0, a register-file read value and the zero and overflow flags left by the last ALU operation, it works out the next program counter.

It also owns an 8-bit loop counter, called the stage counter. Dedicated ALU instructions add to it, subtract from it or clear it. A branch kind of its own tests the stage counter against an immediate. This lets loops be written without using R0.

The next PC is combinational and is valid in the same cycle as the instruction. The stage counter is a register. It changes only at a clock edge where `exec_en` is high. Being control logic, the block has plain pins and no valid/ready pairing: the fetch unit asserts `exec_en` in each cycle in which the presented instruction really retires.

Top module: `stage_branch_unit`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it rises, `stage_cnt` is 0.
- R2: An instruction whose bits [31:28] are not 8 gives `next_pc = pc + 1` modulo 2048. So does a branch whose kind field [27:26] is 3.
- R3: An instruction with [31:28]=7 and [27:26]=2 is a stage-counter operation. When it retires, select [24:21] chooses the action:
  - 0 adds imm[11:4] (the low 8 bits of the 16-bit field [19:4]), wrapping modulo 256.
  - 1 subtracts it, wrapping modulo 256.
  - 2 clears the counter.
  - Any other select leaves the counter unchanged.
- R4: `stage_cnt` keeps its value at every edge where `exec_en` is low, or where the instruction is not a stage-counter operation.
- R5: Kind 0 is a relative branch on R0. Its fields are imm [14:0], compare code [17:15], offset magnitude [24:18] and sign [25], where 1 means backward. R0 is compared unsigned against the zero-extended imm. Code 1 means R0 < imm, 2 means R0 > imm and 4 means R0 == imm. Any other code is never taken.
- R6: Kind 2 is a relative branch that uses the same fields and codes as R5. It compares `stage_cnt` unsigned against imm[7:0].
- R7: A taken relative branch gives `pc + offset` or `pc - offset` modulo 2048. A relative branch that is not taken gives `pc + 1`.
- R8: Kind 1 is an absolute jump. Its fields are register select [1:0], address [12:2], from-register flag [21] and type [24:22]. Type 0 always jumps. Type 1 jumps only when `zero_flag` is 1. Type 2 jumps only when `ovf_flag` is 1. Any other type, or a condition that fails, gives `pc + 1`.
- R9: An absolute jump with flag [21] set targets `reg_val[10:0]`. `jmp_reg_sel` always shows instruction bits [1:0].
- R10: A stage-compare branch that follows a counter update uses the updated value, with no stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | The presented instruction retires at this edge |
| insn | input | 32 | Instruction word |
| pc | input | 11 | Current program counter, in words |
| r0 | input | 16 | Value of R0 |
| reg_val | input | 16 | Register-file value read through `jmp_reg_sel` |
| zero_flag | input | 1 | Last ALU result was zero |
| ovf_flag | input | 1 | Last ALU operation overflowed |
| jmp_reg_sel | output | 2 | Register index for a register-target jump |
| next_pc | output | 11 | Program counter for the following instruction |
| stage_cnt | output | 8 | Current stage counter |

## Verification
Two functions meet when a counter update is followed directly by a stage-compare branch. The update lands at the clock edge, and the branch decoded in the very next cycle must already compare against the new value. This is provoked by retiring an add of 5 and then, in the next cycle, an equal-to-5 branch. It is repeated with a decrement that wraps below zero. The case is judged by whether `next_pc` takes the branch. A reference model runs beside the design and compares `next_pc`, `stage_cnt` and `jmp_reg_sel` every cycle, during the directed cases and during a long random instruction mix biased toward near-equal compares.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam logic [3:0] OPC_BRANCH = 4'd8;
  localparam logic [3:0] OPC_ALU    = 4'd7;
  localparam logic [1:0] ALU_SUB_STAGE = 2'd2;

  typedef enum logic [1:0] {
    BK_REL_R0  = 2'd0,
    BK_ABS     = 2'd1,
    BK_REL_STG = 2'd2,
    BK_RSVD    = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    SOP_NONE = 2'd0,
    SOP_ADD  = 2'd1,
    SOP_SUB  = 2'd2,
    SOP_CLR  = 2'd3
  } stg_op_e;

  localparam logic [2:0] CMP_LT = 3'd1;
  localparam logic [2:0] CMP_GT = 3'd2;
  localparam logic [2:0] CMP_EQ = 3'd4;

  localparam logic [2:0] JT_ALWAYS = 3'd0;
  localparam logic [2:0] JT_ZERO   = 3'd1;
  localparam logic [2:0] JT_OVF    = 3'd2;
endpackage

// File: rtl/sbu_decode.sv
module sbu_decode
  import sbu_pkg::*;
(
  input  logic [31:0] insn,
  output logic        is_abs,
  output logic        is_rel_r0,
  output logic        is_rel_stg,
  output stg_op_e     stg_op,
  output logic [14:0] rel_imm,
  output logic [2:0]  rel_cmp,
  output logic [6:0]  rel_mag,
  output logic        rel_back,
  output logic [1:0]  abs_rsel,
  output logic [10:0] abs_addr,
  output logic        abs_from_reg,
  output logic [2:0]  abs_type,
  output logic [15:0] stg_imm
);
  logic [3:0] opc;
  br_kind_e   kind;
  logic       is_br;

  assign opc   = insn[31:28];
  assign kind  = br_kind_e'(insn[27:26]);
  assign is_br = (opc == OPC_BRANCH);

  assign is_abs     = is_br && (kind == BK_ABS);
  assign is_rel_r0  = is_br && (kind == BK_REL_R0);
  assign is_rel_stg = is_br && (kind == BK_REL_STG);

  assign rel_imm  = insn[14:0];
  assign rel_cmp  = insn[17:15];
  assign rel_mag  = insn[24:18];
  assign rel_back = insn[25];

  assign abs_rsel     = insn[1:0];
  assign abs_addr     = insn[12:2];
  assign abs_from_reg = insn[21];
  assign abs_type     = insn[24:22];

  assign stg_imm = insn[19:4];

  always_comb begin
    stg_op = SOP_NONE;
    if (opc == OPC_ALU && insn[27:26] == ALU_SUB_STAGE) begin
      unique case (insn[24:21])
        4'd0:    stg_op = SOP_ADD;
        4'd1:    stg_op = SOP_SUB;
        4'd2:    stg_op = SOP_CLR;
        default: stg_op = SOP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sbu_stage_ctr.sv
module sbu_stage_ctr
  import sbu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_en,
  input  stg_op_e          op,
  input  logic [CNT_W-1:0] imm,
  output logic [CNT_W-1:0] cnt
);
  logic upd;
  assign upd = exec_en && (op != SOP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (upd) begin
      unique case (op)
        SOP_ADD: cnt <= cnt + imm;
        SOP_SUB: cnt <= cnt - imm;
        SOP_CLR: cnt <= '0;
        default: cnt <= cnt;
      endcase
    end
  end

  // R1: counter is zero at the first edge after reset release
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cnt == '0);

  // R4: no retirement of a counter op, no change
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en || op == SOP_NONE) |=> $stable(cnt));

  // R3: a retired clear leaves zero
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op == SOP_CLR) |=> cnt == '0);
endmodule

// File: rtl/sbu_pc_calc.sv
module sbu_pc_calc
  import sbu_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_abs,
  input  logic              is_rel_r0,
  input  logic              is_rel_stg,
  input  logic [14:0]       rel_imm,
  input  logic [2:0]        rel_cmp,
  input  logic [6:0]        rel_mag,
  input  logic              rel_back,
  input  logic [10:0]       abs_addr,
  input  logic              abs_from_reg,
  input  logic [2:0]        abs_type,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] r0,
  input  logic [DATA_W-1:0] reg_val,
  input  logic              zero_flag,
  input  logic              ovf_flag,
  input  logic [CNT_W-1:0]  cnt,
  output logic [PC_W-1:0]   next_pc
);
  logic [PC_W-1:0]   pc_inc, rel_tgt, abs_tgt;
  logic [DATA_W-1:0] cmp_a, cmp_b;
  logic              rel_hit, abs_hit;
  logic [DATA_W-PC_W-1:0] unused_reg_hi;

  assign unused_reg_hi = reg_val[DATA_W-1:PC_W];

  function automatic logic cmp_ok(input logic [2:0] code,
                                  input logic [DATA_W-1:0] a,
                                  input logic [DATA_W-1:0] b);
    unique case (code)
      CMP_LT:  return a < b;
      CMP_GT:  return a > b;
      CMP_EQ:  return a == b;
      default: return 1'b0;
    endcase
  endfunction

  assign cmp_a = is_rel_stg ? DATA_W'(cnt) : r0;
  assign cmp_b = is_rel_stg ? DATA_W'(rel_imm[CNT_W-1:0]) : DATA_W'(rel_imm);
  assign rel_hit = cmp_ok(rel_cmp, cmp_a, cmp_b);

  assign pc_inc  = pc + PC_W'(1);
  assign rel_tgt = rel_back ? pc - PC_W'(rel_mag) : pc + PC_W'(rel_mag);
  assign abs_tgt = abs_from_reg ? reg_val[PC_W-1:0] : PC_W'(abs_addr);

  always_comb begin
    unique case (abs_type)
      JT_ALWAYS: abs_hit = 1'b1;
      JT_ZERO:   abs_hit = zero_flag;
      JT_OVF:    abs_hit = ovf_flag;
      default:   abs_hit = 1'b0;
    endcase
  end

  always_comb begin
    next_pc = pc_inc;
    if (is_abs && abs_hit)
      next_pc = abs_tgt;
    else if ((is_rel_r0 || is_rel_stg) && rel_hit)
      next_pc = rel_tgt;
  end

  // R2: anything that is not a decoded branch falls through
  assert_fallthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_abs || is_rel_r0 || is_rel_stg) |-> next_pc == PC_W'(pc + 1'b1));

  // R7: relative branches never reach more than 127 words away
  assert_rel_reach_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rel_r0 || is_rel_stg) |->
      (PC_W'(next_pc - pc) <= PC_W'(127) || PC_W'(pc - next_pc) <= PC_W'(127)));

  // R8: an undefined jump type is never taken
  assert_bad_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_abs && abs_type > 3'd2) |-> next_pc == PC_W'(pc + 1'b1));
endmodule

// File: rtl/stage_branch_unit.sv
module stage_branch_unit
  import sbu_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [31:0]       insn,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] r0,
  input  logic [DATA_W-1:0] reg_val,
  input  logic              zero_flag,
  input  logic              ovf_flag,
  output logic [1:0]        jmp_reg_sel,
  output logic [PC_W-1:0]   next_pc,
  output logic [CNT_W-1:0]  stage_cnt
);
  logic        d_abs, d_rel_r0, d_rel_stg, d_back, d_from_reg;
  stg_op_e     d_sop;
  logic [14:0] d_imm;
  logic [2:0]  d_cmp, d_type;
  logic [6:0]  d_mag;
  logic [10:0] d_addr;
  logic [15:0] d_stg_imm;
  logic [15-CNT_W:0] unused_stg_hi;

  assign unused_stg_hi = d_stg_imm[15:CNT_W];

  sbu_decode u_dec (
    .insn(insn), .is_abs(d_abs), .is_rel_r0(d_rel_r0), .is_rel_stg(d_rel_stg),
    .stg_op(d_sop), .rel_imm(d_imm), .rel_cmp(d_cmp), .rel_mag(d_mag),
    .rel_back(d_back), .abs_rsel(jmp_reg_sel), .abs_addr(d_addr),
    .abs_from_reg(d_from_reg), .abs_type(d_type), .stg_imm(d_stg_imm)
  );

  sbu_stage_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(d_sop),
    .imm(d_stg_imm[CNT_W-1:0]), .cnt(stage_cnt)
  );

  sbu_pc_calc #(.PC_W(PC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .is_abs(d_abs), .is_rel_r0(d_rel_r0),
    .is_rel_stg(d_rel_stg), .rel_imm(d_imm), .rel_cmp(d_cmp), .rel_mag(d_mag),
    .rel_back(d_back), .abs_addr(d_addr), .abs_from_reg(d_from_reg),
    .abs_type(d_type), .pc(pc), .r0(r0), .reg_val(reg_val),
    .zero_flag(zero_flag), .ovf_flag(ovf_flag), .cnt(stage_cnt),
    .next_pc(next_pc)
  );

  // R9: the register select pin mirrors the low instruction bits
  assert_rsel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_reg_sel == insn[1:0]);
endmodule

// File: tb/sim_stage_branch_unit.sv
module sim_stage_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [31:0] insn = '0;
  logic [10:0] pc = '0;
  logic [15:0] r0 = '0;
  logic [15:0] reg_val = '0;
  logic        zero_flag = 1'b0;
  logic        ovf_flag = 1'b0;
  logic [1:0]  jmp_reg_sel;
  logic [10:0] next_pc;
  logic [7:0]  stage_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int mcnt  = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  stage_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .insn(insn), .pc(pc),
    .r0(r0), .reg_val(reg_val), .zero_flag(zero_flag), .ovf_flag(ovf_flag),
    .jmp_reg_sel(jmp_reg_sel), .next_pc(next_pc), .stage_cnt(stage_cnt)
  );

  function automatic logic [31:0] mk_rel(int kind, int back, int mag, int cmp, int imm);
    return {4'd8, 2'(kind), 1'(back), 7'(mag), 3'(cmp), 15'(imm)};
  endfunction
  function automatic logic [31:0] mk_abs(int jt, int fr, int addr, int rs);
    return {4'd8, 2'd1, 1'b0, 3'(jt), 1'(fr), 8'd0, 11'(addr), 2'(rs)};
  endfunction
  function automatic logic [31:0] mk_stg(int sel, int imm);
    return {4'd7, 2'd2, 1'b0, 4'(sel), 1'b0, 16'(imm), 4'd0};
  endfunction

  function automatic bit hit(int code, int a, int b);
    case (code)
      1: return a < b;
      2: return a > b;
      4: return a == b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int model_pc();
    int op, kind, p1, a, b, mag, tgt;
    bit take;
    op = int'(insn[31:28]); kind = int'(insn[27:26]);
    p1 = (int'(pc) + 1) % 2048;
    if (op != 8 || kind == 3) return p1;
    if (kind == 1) begin
      case (int'(insn[24:22]))
        0: take = 1'b1;
        1: take = zero_flag;
        2: take = ovf_flag;
        default: take = 1'b0;
      endcase
      tgt = insn[21] ? (int'(reg_val) % 2048) : int'(insn[12:2]);
      return take ? tgt : p1;
    end
    a = (kind == 0) ? int'(r0) : mcnt;
    b = (kind == 0) ? int'(insn[14:0]) : int'(insn[7:0]);
    mag = int'(insn[24:18]);
    if (!hit(int'(insn[17:15]), a, b)) return p1;
    return insn[25] ? (int'(pc) - mag + 2048) % 2048 : (int'(pc) + mag) % 2048;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [31:0] i, int p, int rr0, int rv,
                      bit z, bit o, bit en);
    @(negedge clk);
    insn = i; pc = 11'(p); r0 = 16'(rr0); reg_val = 16'(rv);
    zero_flag = z; ovf_flag = o; exec_en = en;
    #1;
    check(tag, int'(next_pc), model_pc(), "next_pc");
    check(tag, int'(stage_cnt), mcnt, "stage_cnt");
    check(tag, int'(jmp_reg_sel), int'(i[1:0]), "jmp_reg_sel (R9)");
    if (en && i[31:28] == 4'd7 && i[27:26] == 2'd2) begin
      case (int'(i[24:21]))
        0: mcnt = (mcnt + int'(i[11:4])) % 256;
        1: mcnt = (mcnt - int'(i[11:4]) + 256) % 256;
        2: mcnt = 0;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1", int'(stage_cnt), 0, "stage_cnt in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1", 32'h0, 0, 0, 0, 0, 0, 0);
    // R10: update followed directly by stage compare
    step("R3", mk_stg(0, 5), 10, 0, 0, 0, 0, 1);
    step("R10", mk_rel(2, 0, 3, 4, 5), 11, 0, 0, 0, 0, 1);
    step("R6", mk_rel(2, 0, 3, 1, 5), 14, 0, 0, 0, 0, 1);
    step("R6", mk_rel(2, 1, 2, 2, 16'h7f04), 14, 0, 0, 0, 0, 1);
    step("R3", mk_stg(1, 10), 20, 0, 0, 0, 0, 1);
    step("R10", mk_rel(2, 0, 9, 4, 251), 21, 0, 0, 0, 0, 1);
    step("R3", mk_stg(3, 7), 22, 0, 0, 0, 0, 1);
    step("R4", mk_stg(0, 9), 23, 0, 0, 0, 0, 0);
    step("R4", mk_rel(0, 0, 1, 4, 0), 24, 0, 0, 0, 0, 1);
    step("R3", mk_stg(2, 0), 25, 0, 0, 0, 0, 1);
    step("R3", mk_stg(0, 16'hFFF3), 26, 0, 0, 0, 0, 1);
    step("R5", mk_rel(0, 0, 4, 1, 100), 30, 99, 0, 0, 0, 1);
    step("R5", mk_rel(0, 0, 4, 1, 100), 30, 100, 0, 0, 0, 1);
    step("R5", mk_rel(0, 0, 4, 2, 100), 30, 16'h8000, 0, 0, 0, 1);
    step("R5", mk_rel(0, 0, 4, 4, 100), 30, 100, 0, 0, 0, 1);
    step("R5", mk_rel(0, 0, 4, 3, 100), 30, 50, 0, 0, 0, 1);
    step("R7", mk_rel(0, 1, 5, 4, 7), 2, 7, 0, 0, 0, 1);
    step("R7", mk_rel(0, 0, 127, 4, 7), 2040, 7, 0, 0, 0, 1);
    step("R8", mk_abs(0, 0, 1234, 0), 5, 0, 0, 0, 0, 1);
    step("R8", mk_abs(1, 0, 77, 1), 5, 0, 0, 0, 0, 1);
    step("R8", mk_abs(1, 0, 77, 1), 5, 0, 0, 1, 0, 1);
    step("R8", mk_abs(2, 0, 88, 2), 5, 0, 0, 0, 1, 1);
    step("R8", mk_abs(5, 0, 88, 2), 5, 0, 0, 1, 1, 1);
    step("R9", mk_abs(0, 1, 3, 3), 5, 0, 16'hFFFF, 0, 0, 1);
    step("R2", 32'hB000_0000 | mk_rel(3, 0, 1, 4, 0), 2047, 0, 0, 1, 1, 1);
    step("R2", mk_rel(3, 0, 1, 4, 0), 9, 0, 0, 0, 0, 1);
    for (int k = 0; k < 3000; k++) begin
      int sel;
      logic [31:0] ins;
      string tg;
      sel = int'($urandom % 5);
      case (sel)
        0: begin ins = mk_rel(0, $urandom % 2, $urandom % 128, $urandom % 8, $urandom % 64); tg = "R5"; end
        1: begin ins = mk_rel(2, $urandom % 2, $urandom % 128, $urandom % 8,
                   (int'($urandom % 128) << 8) | ((mcnt + int'($urandom % 3) + 255) % 256)); tg = "R6"; end
        2: begin ins = mk_abs($urandom % 8, $urandom % 2, $urandom % 2048, $urandom % 4); tg = "R8"; end
        3: begin ins = mk_stg($urandom % 16, $urandom % 65536); tg = "R3"; end
        default: begin ins = $urandom; tg = "R2"; end
      endcase
      step(tg, ins, $urandom % 2048, $urandom % 64, $urandom, $urandom % 2,
           $urandom % 2, ($urandom % 4) != 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule